// File: doc/BRIEF.md
# Burst-Aware Round-Robin Port Arbiter

This block decides which of several bus masters owns a single shared memory controller port. Each master raises a request and describes the transfer it wants to make: a single access, a burst of declared length, or an incrementing burst of open length. The memory side signals each accepted data beat. The arbiter hands the port over only at points where a handover does not split a burst. These points are an idle port, the end of a single access, a predicted burst end, or a master flagging an early (lookahead) access.

Rotation is fair. The master just served drops to lowest priority at the next decision. After reset the lowest-numbered requester wins a tie. At a decision point, requesters that raise the lookahead flag are considered before the others, so a lookahead can override the plain rotation choice. The port is granted through a registered one-hot vector and an owner index. Command sequencing, bank timing and data movement belong to the surrounding controller.

Top module: `burst_rr_arb`

## Requirements
- R1: After reset, `gnt_o` is all-zero and `owner_o` is 0.
- R2: While no master owns the port, a request is granted on the next clock edge. If there are no requests, `gnt_o` goes to or stays at all-zero.
- R3: After reset, when several masters request in the same cycle, the lowest-numbered one is granted first.
- R4: At each decision point the search starts one index above the master last granted, wrapping at the top. Non-requesting masters are skipped.
- R5: A transfer of type single (code 2'b00 in `xfer_i[2k+1:2k]`) releases the port with its first accepted beat.
- R6: A fixed-length burst (code 2'b01) keeps the port until the beat whose count equals its declared length `len_i[LEN_W*k +: LEN_W]` (1 or more). It is released at that beat.
- R7: An open-length incrementing burst (code 2'b10) reaches a decision point at every fourth accepted beat.
- R8: Only cycles with `beat_i` high advance the beat count. Without beats, the owner keeps the port whatever the other requests do.
- R9: At a decision point, if any requesting master has `ahead_i` set, the rotation is applied only among those masters. This may override the plain rotation choice.
- R10: `gnt_o` is one-hot or zero, matches `owner_o` when non-zero, and does not change between decision points.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | N_MASTERS | Request per master |
| ahead_i | input | N_MASTERS | Lookahead access pending per master |
| xfer_i | input | 2*N_MASTERS | Transfer type per master, 2 bits each |
| len_i | input | LEN_W*N_MASTERS | Declared fixed-burst length per master |
| beat_i | input | 1 | Data beat of the current owner accepted this cycle |
| gnt_o | output | N_MASTERS | One-hot grant |
| owner_o | output | $clog2(N_MASTERS) | Index of current owner |

## Verification
The properties assume that `beat_i` is raised only while a master owns the port. They also assume that a master's `xfer_i` and `len_i` are valid in the cycle it is granted, and that declared fixed lengths are non-zero. The stimulus changes inputs only between clock edges, pulses `beat_i` only after a grant is visible, and sets each master's mode before raising its request. Under these conditions the grant can only move on a cycle that the arbiter marks as a decision point.

// File: rtl/burst_arb_pkg.sv
`timescale 1ns/1ps
package burst_arb_pkg;
  typedef enum logic [1:0] {
    XFER_SINGLE = 2'b00,
    XFER_FIXED  = 2'b01,
    XFER_INCR   = 2'b10
  } xfer_e;
endpackage

// File: rtl/rr_pick.sv
`timescale 1ns/1ps
module rr_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  // walk from farthest to nearest so the nearest hit from ptr wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int pos;
      pos = (int'(ptr_i) + k) % N;
      if (req_i[IDX_W'(pos)]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(pos);
      end
    end
  end
endmodule

// File: rtl/beat_tracker.sv
`timescale 1ns/1ps
module beat_tracker
  import burst_arb_pkg::*;
#(
  parameter int LEN_W     = 4,
  parameter int INCR_SPAN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  xfer_e            xfer_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             beat_i,
  output logic             last_o
);
  localparam int SPAN_W = $clog2(INCR_SPAN);

  xfer_e            kind_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W:0]   cnt_nx;

  assign cnt_nx = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    unique case (kind_q)
      XFER_FIXED: last_o = (cnt_nx == {1'b0, len_q});
      XFER_INCR:  last_o = (cnt_nx[SPAN_W-1:0] == '0);
      default:    last_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= XFER_SINGLE;
      len_q  <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      kind_q <= xfer_i;
      len_q  <= len_i;
      cnt_q  <= '0;
    end else if (beat_i) begin
      cnt_q  <= cnt_nx[LEN_W-1:0];
    end
  end
endmodule

// File: rtl/burst_rr_arb.sv
`timescale 1ns/1ps
module burst_rr_arb
  import burst_arb_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int LEN_W     = 4,
  parameter int INCR_SPAN = 4,
  localparam int IDX_W    = $clog2(N_MASTERS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_MASTERS-1:0]       req_i,
  input  logic [N_MASTERS-1:0]       ahead_i,
  input  logic [2*N_MASTERS-1:0]     xfer_i,
  input  logic [LEN_W*N_MASTERS-1:0] len_i,
  input  logic                       beat_i,
  output logic [N_MASTERS-1:0]       gnt_o,
  output logic [IDX_W-1:0]           owner_o
);
  logic             owned_q;
  logic [IDX_W-1:0] owner_q, ptr_q;
  logic             last, arb_pt, found;
  logic [IDX_W-1:0] win;
  logic [N_MASTERS-1:0] cand, ahead_req;
  xfer_e            xfer_arr [N_MASTERS];
  logic [LEN_W-1:0] len_arr  [N_MASTERS];

  for (genvar g = 0; g < N_MASTERS; g++) begin : g_unpack
    assign xfer_arr[g] = xfer_e'(xfer_i[2*g +: 2]);
    assign len_arr[g]  = len_i[LEN_W*g +: LEN_W];
  end

  assign arb_pt    = !owned_q || (beat_i && last);
  assign ahead_req = req_i & ahead_i;
  assign cand      = (|ahead_req) ? ahead_req : req_i;

  rr_pick #(.N(N_MASTERS), .IDX_W(IDX_W)) u_pick (
    .req_i   (cand),
    .ptr_i   (ptr_q),
    .found_o (found),
    .idx_o   (win)
  );

  beat_tracker #(.LEN_W(LEN_W), .INCR_SPAN(INCR_SPAN)) u_trk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (arb_pt && found),
    .xfer_i (xfer_arr[win]),
    .len_i  (len_arr[win]),
    .beat_i (beat_i && owned_q),
    .last_o (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owned_q <= 1'b0;
      owner_q <= '0;
      ptr_q   <= '0;
    end else if (arb_pt) begin
      owned_q <= found;
      if (found) begin
        owner_q <= win;
        ptr_q   <= (int'(win) == N_MASTERS - 1) ? '0 : IDX_W'(int'(win) + 1);
      end
    end
  end

  always_comb begin
    gnt_o = '0;
    if (owned_q) gnt_o[owner_q] = 1'b1;
  end

  assign owner_o = owner_q;
endmodule

// File: rtl/burst_rr_arb_chk.sv
`timescale 1ns/1ps
module burst_rr_arb_chk #(
  parameter int N_MASTERS = 4,
  localparam int IDX_W    = $clog2(N_MASTERS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [N_MASTERS-1:0] req_i,
  input logic [N_MASTERS-1:0] gnt_o,
  input logic [IDX_W-1:0]     owner_o,
  input logic                 arb_pt_i
);
  p_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  p_owner_match_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |-> gnt_o[owner_o]);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arb_pt_i |=> $stable(gnt_o));

  p_grant_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_pt_i && |req_i) |=> (|gnt_o));

  p_drop_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_pt_i && !(|req_i)) |=> (gnt_o == '0));

  p_from_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_pt_i |=> ((gnt_o & $past(req_i)) == gnt_o));
endmodule

bind burst_rr_arb burst_rr_arb_chk #(.N_MASTERS(N_MASTERS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .gnt_o    (gnt_o),
  .owner_o  (owner_o),
  .arb_pt_i (arb_pt)
);

// File: tb/burst_rr_arb_tb_top.sv
`timescale 1ns/1ps
module burst_rr_arb_tb_top;
  localparam int N = 4;
  localparam int LW = 4;

  typedef struct {
    logic [N-1:0] gnt;
    string        tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0, ahead = '0;
  logic [2*N-1:0] xfer = '0;
  logic [LW*N-1:0] len = '0;
  logic          beat = 1'b0;
  logic [N-1:0]  gnt;
  logic [1:0]    owner;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  burst_rr_arb #(.N_MASTERS(N), .LEN_W(LW), .INCR_SPAN(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ahead_i(ahead),
    .xfer_i(xfer), .len_i(len), .beat_i(beat), .gnt_o(gnt), .owner_o(owner)
  );

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  // 0 single, 1 fixed, 2 incr
  task automatic set_mode(input int m, input logic [1:0] kind, input logic [LW-1:0] l);
    xfer[2*m +: 2] = kind;
    len[LW*m +: LW] = l;
  endtask

  task automatic drive(input logic [N-1:0] r, input logic [N-1:0] a, input logic b,
                       input logic [N-1:0] eg, input string tag);
    exp_t e;
    @(negedge clk); #1;
    req = r; ahead = a; beat = b;
    e.gnt = eg; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(gnt === e.gnt, e.tag, $sformatf("gnt=%b", gnt), $sformatf("gnt=%b", e.gnt));
      if (e.gnt != '0) begin
        int idx = 0;
        for (int i = 0; i < N; i++) if (e.gnt[i]) idx = i;
        check(int'(owner) == idx, {e.tag, " R10 owner"},
              $sformatf("owner=%0d", owner), $sformatf("owner=%0d", idx));
      end
    end
  end

  initial begin
    #(8 * 5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(gnt === '0 && owner === 2'd0, "R1 reset",
          $sformatf("gnt=%b owner=%0d", gnt, owner), "gnt=0000 owner=0");
    rst_n = 1'b1;

    // all single
    for (int m = 0; m < N; m++) set_mode(m, 2'b00, 4'd1);
    drive(4'b0000, 4'b0000, 0, 4'b0000, "R2 idle no req");
    drive(4'b1111, 4'b0000, 0, 4'b0001, "R3 lowest wins");
    drive(4'b1111, 4'b0000, 1, 4'b0010, "R4 R5 rotate to 1");
    drive(4'b1111, 4'b0000, 1, 4'b0100, "R4 rotate to 2");
    drive(4'b1111, 4'b0000, 1, 4'b1000, "R4 rotate to 3");
    drive(4'b1111, 4'b0000, 1, 4'b0001, "R4 wrap to 0");
    drive(4'b0000, 4'b0000, 1, 4'b0000, "R2 release to idle");

    // no beats: owner holds
    drive(4'b0001, 4'b0000, 0, 4'b0001, "R2 idle grant");
    drive(4'b0011, 4'b0000, 0, 4'b0001, "R8 hold without beat");
    drive(4'b0011, 4'b0000, 0, 4'b0001, "R8 hold without beat 2");
    drive(4'b0011, 4'b0000, 1, 4'b0010, "R5 single released");
    drive(4'b0000, 4'b0000, 1, 4'b0000, "R2 idle again");

    // fixed burst len 3 on master 2
    set_mode(2, 2'b01, 4'd3);
    drive(4'b1100, 4'b0000, 0, 4'b0100, "R6 fixed granted");
    drive(4'b1100, 4'b0000, 1, 4'b0100, "R6 beat1 hold");
    drive(4'b1100, 4'b0000, 0, 4'b0100, "R8 gap hold");
    drive(4'b1100, 4'b0000, 1, 4'b0100, "R6 beat2 hold");
    drive(4'b1100, 4'b0000, 1, 4'b1000, "R6 end at len");
    drive(4'b0000, 4'b0000, 1, 4'b0000, "R5 single end idle");

    // incr burst on master 0
    set_mode(0, 2'b10, 4'd0);
    drive(4'b0011, 4'b0000, 0, 4'b0001, "R7 incr granted");
    drive(4'b0011, 4'b0000, 1, 4'b0001, "R7 beat1 hold");
    drive(4'b0011, 4'b0000, 1, 4'b0001, "R7 beat2 hold");
    drive(4'b0011, 4'b0000, 1, 4'b0001, "R7 beat3 hold");
    drive(4'b0011, 4'b0000, 1, 4'b0010, "R7 boundary at beat4");
    drive(4'b0001, 4'b0000, 1, 4'b0001, "R7 regrant incr");
    drive(4'b0011, 4'b0000, 1, 4'b0001, "R7 b1");
    drive(4'b0011, 4'b0000, 1, 4'b0001, "R7 b2");
    drive(4'b0011, 4'b0000, 1, 4'b0001, "R7 b3");
    drive(4'b0011, 4'b0000, 1, 4'b0010, "R7 second boundary");
    drive(4'b0000, 4'b0000, 1, 4'b0000, "R2 idle");

    // lookahead overrides rotation (rotation would pick 3)
    for (int m = 0; m < N; m++) set_mode(m, 2'b00, 4'd1);
    drive(4'b1011, 4'b0001, 0, 4'b0001, "R9 lookahead wins");
    drive(4'b1011, 4'b0000, 1, 4'b0010, "R4 after lookahead");
    drive(4'b1011, 4'b0000, 1, 4'b1000, "R4 skip idle master");
    drive(4'b0000, 4'b0000, 1, 4'b0000, "R2 final idle");

    @(negedge clk); @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule